// File: doc/BRIEF.md
# Temperature Alarm With Fault Queue

This block watches a stream of 16-bit two's-complement temperature results (1/128 °C per LSB) and raises two alarm levels: a general alarm for results outside a high/low window and a critical alarm for results above a critical limit. Each new result arrives with a one-cycle valid strobe. A programmable consecutive-fault queue filters noisy readings, so an alarm can activate only after 1 to 4 back-to-back out-of-limit results. Release thresholds are built from a 4-bit hysteresis in whole degrees, which is scaled by 128 into the result format.

Each alarm has its own small state machine with three named states: `ALM_IDLE` (inactive and armed), `ALM_ACTIVE` (asserted) and `ALM_CLEARED` (inactive after an acknowledge, waiting to re-arm). The transitions are: IDLE to ACTIVE on a qualified fault; ACTIVE to IDLE on a release conversion (comparator mode); ACTIVE to CLEARED on a register read, or on shutdown for the general alarm only (interrupt mode); CLEARED to IDLE on a release conversion. The block also keeps three sticky status flags and builds the value word a register read would return, with the flags folded into its three low bits at 13-bit resolution. Only logic levels are produced; pad drivers lie outside.

Top module: `temp_alarm`

## Requirements
- R1: Config bits 1:0 set how many consecutive out-of-limit conversions are needed before an alarm activates: code 00 needs 1, 01 needs 2, 10 needs 3, 11 needs 4; fewer leave the alarm inactive.
- R2: Any conversion that is not a fault for an alarm resets that alarm's consecutive count to zero, so the full count must be reached again.
- R3: A result is a general fault when it is strictly greater than the high limit or strictly less than the low limit, and a critical fault when strictly greater than the critical limit; all comparisons are signed, and equality is not a fault.
- R4: With hysteresis H degrees, the release thresholds are high − 128·H, low + 128·H and critical − 128·H; a conversion releases the general alarm only when strictly below the first and strictly above the second, and the critical alarm only when strictly below the third.
- R5: Config bit 3 sets the general alarm polarity and bit 2 the critical alarm polarity: 0 drives the pin low when active (high when inactive), 1 drives it high when active.
- R6: With config bit 4 = 1 (comparator mode) an active alarm stays active until a release conversion; register reads, status reads and shutdown have no effect on it.
- R7: With config bit 4 = 0 (interrupt mode) a register read or status read deactivates both active alarms; shutdown deactivates only the general alarm.
- R8: In interrupt mode, an alarm deactivated by a read or shutdown stays inactive through further faults until a release conversion has occurred; after that a new qualified fault activates it again.
- R9: status_flags bit 2 (critical), bit 1 (above high) and bit 0 (below low) set on a qualified fault of that kind and clear on a status read or on a conversion past that limit's release threshold; a new set in the same cycle wins.
- R10: With config bit 7 = 1 the value word is the last result unchanged; with bit 7 = 0 its bits 15:3 are the last result's bits 15:3 and bits 2:0 are status_flags bits 2:0.
- R11: After reset both alarms are inactive (pins at the inactive level of their polarity), the fault counts and flags are zero and the value word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | One-cycle strobe: a new result is on res_word |
| res_word | input | 16 | Temperature result, two's complement, 1/128 °C per LSB |
| cfg_word | input | 8 | Configuration: queue code, polarities, mode, resolution |
| lim_crit | input | 16 | Critical limit, signed |
| lim_high | input | 16 | High limit, signed |
| lim_low | input | 16 | Low limit, signed |
| hyst_deg | input | 4 | Hysteresis in whole degrees |
| reg_read | input | 1 | Strobe: some register is being read |
| status_read | input | 1 | Strobe: the status register is being read |
| shutdown | input | 1 | High while the sensor is powered down |
| int_out | output | 1 | General alarm pin level |
| ct_out | output | 1 | Critical alarm pin level |
| status_flags | output | 3 | Sticky flags: critical, above high, below low |
| value_word | output | 16 | Value word as a register read would return it |

## Verification
The assertions take for granted that a result strobe and shutdown are never high together, that the configuration and limits change only between conversions, and that the limits are ordered low below high below critical with enough room that the hysteresis bands do not cross. The stimulus draws configuration and hysteresis per phase, holds them fixed during that phase, keeps the three limits at fixed ordered values, and only raises shutdown in cycles without a result. Results are drawn around each limit and each release threshold, with a small offset so that equality and one-LSB-past cases appear often, plus occasional fully random values including negative ones.

// File: rtl/temp_alarm_pkg.sv
package temp_alarm_pkg;

    typedef enum logic [1:0] {
        ALM_IDLE    = 2'd0,
        ALM_ACTIVE  = 2'd1,
        ALM_CLEARED = 2'd2
    } alm_state_t;

    localparam int CFG_W        = 8;
    localparam int CFG_QUEUE_LSB = 0;
    localparam int CFG_CT_POL   = 2;
    localparam int CFG_INT_POL  = 3;
    localparam int CFG_CMP_MODE = 4;
    localparam int CFG_RES16    = 7;

    localparam int NUM_CH  = 2;
    localparam int CH_INT  = 0;
    localparam int CH_CT   = 1;

    localparam int FLAG_N    = 3;
    localparam int FLAG_LOW  = 0;
    localparam int FLAG_HIGH = 1;
    localparam int FLAG_CRIT = 2;

endpackage

// File: rtl/alarm_compare.sv
module alarm_compare #(
    parameter int TW     = 16,
    parameter int HW     = 4,
    parameter int HSHIFT = 7
) (
    input  logic [TW-1:0] res,
    input  logic [TW-1:0] crit,
    input  logic [TW-1:0] high,
    input  logic [TW-1:0] low,
    input  logic [HW-1:0] hyst,
    output logic          above_high,
    output logic          below_low,
    output logic          above_crit,
    output logic          high_rel,
    output logic          low_rel,
    output logic          crit_rel
);
    localparam int EW = TW + 2;

    logic signed [EW-1:0] r_e, c_e, h_e, l_e, hs_e;

    always_comb begin
        r_e  = EW'($signed(res));
        c_e  = EW'($signed(crit));
        h_e  = EW'($signed(high));
        l_e  = EW'($signed(low));
        hs_e = $signed({{(EW-HW){1'b0}}, hyst}) <<< HSHIFT;

        above_high = r_e > h_e;
        below_low  = r_e < l_e;
        above_crit = r_e > c_e;
        high_rel   = r_e < (h_e - hs_e);
        low_rel    = r_e > (l_e + hs_e);
        crit_rel   = r_e < (c_e - hs_e);
    end

endmodule

// File: rtl/fault_queue.sv
module fault_queue #(
    parameter int QW = 2,
    localparam int CW = QW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv,
    input  logic          fault,
    input  logic [QW-1:0] code,
    output logic          qual
);
    logic [CW-1:0] need, cnt_q, cnt_d;

    always_comb begin
        need  = CW'(code) + CW'(1);
        cnt_d = cnt_q;
        if (conv) begin
            if (!fault)
                cnt_d = '0;
            else if (cnt_q >= need)
                cnt_d = need;
            else
                cnt_d = cnt_q + CW'(1);
        end
        qual = conv && fault && (cnt_d == need);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        conv |=> (cnt_q <= $past(need)));                                  // R1
    AST_QUEUE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (conv && !fault) |=> (cnt_q == '0));                               // R2

endmodule

// File: rtl/alarm_fsm.sv
module alarm_fsm
    import temp_alarm_pkg::*;
#(
    parameter bit CLR_ON_SHDN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_mode,
    input  logic conv,
    input  logic qual,
    input  logic rel,
    input  logic rd_any,
    input  logic shdn,
    output logic active
);
    alm_state_t st_q, st_d;
    logic       clr_req;

    assign clr_req = rd_any || (CLR_ON_SHDN && shdn);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ALM_IDLE:    if (qual) st_d = ALM_ACTIVE;
            ALM_ACTIVE: begin
                if (cmp_mode) begin
                    if (conv && rel) st_d = ALM_IDLE;
                end else if (clr_req) begin
                    st_d = ALM_CLEARED;
                end
            end
            ALM_CLEARED: if (conv && rel) st_d = ALM_IDLE;
            default:     st_d = ALM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ALM_IDLE;
        else
            st_q <= st_d;
    end

    always_comb begin
        active = (st_q == ALM_ACTIVE);
    end

    AST_RISE_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ALM_ACTIVE && !qual) |=> (st_q != ALM_ACTIVE));           // R1
    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_mode && st_q == ALM_ACTIVE && !conv) |=> (st_q == ALM_ACTIVE)); // R6
    AST_INTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_mode && st_q == ALM_ACTIVE && clr_req) |=> (st_q == ALM_CLEARED)); // R7
    AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ALM_CLEARED && !(conv && rel)) |=> (st_q != ALM_ACTIVE)); // R8

endmodule

// File: rtl/status_flags.sv
module status_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv,
    input  logic         status_read,
    input  logic [N-1:0] set,
    input  logic [N-1:0] rel,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set[i])
                flags[i] <= 1'b1;
            else if (status_read || (conv && rel[i]))
                flags[i] <= 1'b0;
        end

        AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);                                          // R9
        AST_FLAG_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (status_read && !set[i]) |=> !flags[i]);                       // R9
        AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (!conv && !status_read) |=> $stable(flags[i]));                // R9
    end

endmodule

// File: rtl/temp_alarm.sv
module temp_alarm
    import temp_alarm_pkg::*;
#(
    parameter int TW     = 16,
    parameter int HW     = 4,
    parameter int HSHIFT = 7,
    parameter int QW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [TW-1:0]     res_word,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [TW-1:0]     lim_crit,
    input  logic [TW-1:0]     lim_high,
    input  logic [TW-1:0]     lim_low,
    input  logic [HW-1:0]     hyst_deg,
    input  logic              reg_read,
    input  logic              status_read,
    input  logic              shutdown,
    output logic              int_out,
    output logic              ct_out,
    output logic [FLAG_N-1:0] status_flags,
    output logic [TW-1:0]     value_word
);
    logic above_high, below_low, above_crit;
    logic high_rel, low_rel, crit_rel;
    logic [NUM_CH-1:0] ch_fault, ch_rel, ch_qual, ch_act;
    logic [FLAG_N-1:0] flag_set, flag_rel;
    logic [TW-1:0]     res_q;
    logic              rd_any;

    alarm_compare #(.TW(TW), .HW(HW), .HSHIFT(HSHIFT)) u_cmp (
        .res        (res_word),
        .crit       (lim_crit),
        .high       (lim_high),
        .low        (lim_low),
        .hyst       (hyst_deg),
        .above_high (above_high),
        .below_low  (below_low),
        .above_crit (above_crit),
        .high_rel   (high_rel),
        .low_rel    (low_rel),
        .crit_rel   (crit_rel)
    );

    always_comb begin
        rd_any           = reg_read || status_read;
        ch_fault[CH_INT] = above_high || below_low;
        ch_fault[CH_CT]  = above_crit;
        ch_rel[CH_INT]   = high_rel && low_rel;
        ch_rel[CH_CT]    = crit_rel;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        fault_queue #(.QW(QW)) u_queue (
            .clk   (clk),
            .rst_n (rst_n),
            .conv  (res_valid),
            .fault (ch_fault[ch]),
            .code  (cfg_word[CFG_QUEUE_LSB +: QW]),
            .qual  (ch_qual[ch])
        );

        alarm_fsm #(.CLR_ON_SHDN(ch == CH_INT)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmp_mode (cfg_word[CFG_CMP_MODE]),
            .conv     (res_valid),
            .qual     (ch_qual[ch]),
            .rel      (ch_rel[ch]),
            .rd_any   (rd_any),
            .shdn     (shutdown),
            .active   (ch_act[ch])
        );
    end

    always_comb begin
        flag_set[FLAG_CRIT] = ch_qual[CH_CT];
        flag_set[FLAG_HIGH] = ch_qual[CH_INT] && above_high;
        flag_set[FLAG_LOW]  = ch_qual[CH_INT] && below_low;
        flag_rel[FLAG_CRIT] = crit_rel;
        flag_rel[FLAG_HIGH] = high_rel;
        flag_rel[FLAG_LOW]  = low_rel;
    end

    status_flags #(.N(FLAG_N)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv        (res_valid),
        .status_read (status_read),
        .set         (flag_set),
        .rel         (flag_rel),
        .flags       (status_flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_q <= '0;
        else if (res_valid)
            res_q <= res_word;
    end

    always_comb begin
        int_out = cfg_word[CFG_INT_POL] ? ch_act[CH_INT] : !ch_act[CH_INT];
        ct_out  = cfg_word[CFG_CT_POL]  ? ch_act[CH_CT]  : !ch_act[CH_CT];
        if (cfg_word[CFG_RES16])
            value_word = res_q;
        else
            value_word = {res_q[TW-1:FLAG_N], status_flags};
    end

    AST_VALUE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && cfg_word[CFG_RES16]) |=>
        (!cfg_word[CFG_RES16] || value_word == $past(res_word)));          // R10

endmodule

// File: tb/tb_temp_alarm.sv
module tb_temp_alarm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_word = '0;
    logic [7:0]  cfg_word = '0;
    logic [15:0] lim_crit = 16'h4980;
    logic [15:0] lim_high = 16'h2000;
    logic [15:0] lim_low  = 16'h0500;
    logic [3:0]  hyst_deg = '0;
    logic        reg_read = 1'b0;
    logic        status_read = 1'b0;
    logic        shutdown = 1'b0;
    logic        int_out, ct_out;
    logic [2:0]  status_flags;
    logic [15:0] value_word;

    int n_chk = 0;
    int n_fail = 0;

    int          m_st  [2];
    int          m_cnt [2];
    logic [2:0]  m_flags;
    logic [15:0] m_lat;

    always #4 clk = ~clk;

    temp_alarm dut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_word(res_word),
        .cfg_word(cfg_word), .lim_crit(lim_crit), .lim_high(lim_high),
        .lim_low(lim_low), .hyst_deg(hyst_deg), .reg_read(reg_read),
        .status_read(status_read), .shutdown(shutdown), .int_out(int_out),
        .ct_out(ct_out), .status_flags(status_flags), .value_word(value_word)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [20:0] model_out();
        logic ei, ec;
        logic [15:0] vw;
        ei = cfg_word[3] ? (m_st[0] == 1) : (m_st[0] != 1);
        ec = cfg_word[2] ? (m_st[1] == 1) : (m_st[1] != 1);
        vw = cfg_word[7] ? m_lat : {m_lat[15:3], m_flags};
        return {ei, ec, m_flags, vw};
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_st[c] = 0;
            m_cnt[c] = 0;
        end
        m_flags = '0;
        m_lat = '0;
    endtask

    task automatic model_step(input logic v, input logic [15:0] r,
                              input logic rd, input logic srd, input logic sd);
        int rs, hi, lo, cr, hh, need;
        logic [1:0] flt, rel, q;
        logic clr, cmp;
        rs = int'($signed(r));
        hi = int'($signed(lim_high));
        lo = int'($signed(lim_low));
        cr = int'($signed(lim_crit));
        hh = int'(hyst_deg) * 128;
        need = int'(cfg_word[1:0]) + 1;
        cmp = cfg_word[4];
        flt[0] = (rs > hi) || (rs < lo);
        flt[1] = rs > cr;
        rel[0] = (rs < hi - hh) && (rs > lo + hh);
        rel[1] = rs < cr - hh;
        for (int c = 0; c < 2; c++) begin
            q[c] = 1'b0;
            if (v) begin
                if (flt[c]) m_cnt[c] = (m_cnt[c] >= need) ? need : m_cnt[c] + 1;
                else        m_cnt[c] = 0;
                q[c] = flt[c] && (m_cnt[c] == need);
            end
            clr = rd || srd || (c == 0 && sd);
            case (m_st[c])
                0: if (q[c]) m_st[c] = 1;
                1: if (cmp) begin
                       if (v && rel[c]) m_st[c] = 0;
                   end else if (clr) m_st[c] = 2;
                default: if (v && rel[c]) m_st[c] = 0;
            endcase
        end
        if (q[1]) m_flags[2] = 1'b1;
        else if (srd || (v && rs < cr - hh)) m_flags[2] = 1'b0;
        if (q[0] && rs > hi) m_flags[1] = 1'b1;
        else if (srd || (v && rs < hi - hh)) m_flags[1] = 1'b0;
        if (q[0] && rs < lo) m_flags[0] = 1'b1;
        else if (srd || (v && rs > lo + hh)) m_flags[0] = 1'b0;
        if (v) m_lat = r;
    endtask

    // Called at a falling edge; occupies one clock cycle.
    task automatic step(input logic v, input logic [15:0] r, input logic rd,
                        input logic srd, input logic sd, input string tag);
        res_valid = v; res_word = r; reg_read = rd; status_read = srd; shutdown = sd;
        model_step(v, r, rd, srd, sd);
        @(negedge clk);
        res_valid = 1'b0; reg_read = 1'b0; status_read = 1'b0; shutdown = 1'b0;
        check(tag, {11'd0, int_out, ct_out, status_flags, value_word}, {11'd0, model_out()});
    endtask

    task automatic conv(input logic [15:0] r, input string tag);
        step(1'b1, r, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        @(negedge clk);
        do_reset();

        // R11: reset state with active-low polarity
        check("R11 int_out", int_out, 1);
        check("R11 ct_out", ct_out, 1);
        check("R11 flags", status_flags, 0);
        check("R11 value", value_word, 0);

        // R1 queue of four, comparator mode
        cfg_word = 8'h13; hyst_deg = 4'd2; do_reset();
        for (int i = 0; i < 3; i++) begin
            conv(16'h2100, "R1 queue");
            check("R1 below count", int_out, 1);
        end
        conv(16'h2100, "R1 queue");
        check("R1 count reached", int_out, 0);
        // R4 release threshold = high - 256
        conv(16'h1F00, "R4 band");
        check("R4 at threshold holds", int_out, 0);
        conv(16'h1EFF, "R4 band");
        check("R4 past threshold releases", int_out, 1);
        // R2 interrupted run restarts count
        conv(16'h2100, "R2"); conv(16'h2100, "R2");
        conv(16'h1000, "R2");
        conv(16'h2100, "R2"); conv(16'h2100, "R2");
        check("R2 count restarted", int_out, 1);
        conv(16'h2100, "R2"); conv(16'h2100, "R2");
        check("R2 full run", int_out, 0);

        // R3 equality and signed compare
        cfg_word = 8'h10; hyst_deg = 4'd0; do_reset();
        conv(16'h2000, "R3 equal");
        check("R3 equal high no fault", int_out, 1);
        conv(16'h2001, "R3 above");
        check("R3 above high", int_out, 0);
        conv(16'h1000, "R3 release");
        conv(16'hF000, "R3 negative");
        check("R3 negative below low", int_out, 0);
        conv(16'h4980, "R3 crit equal");
        check("R3 crit equal no fault", ct_out, 1);
        conv(16'h4981, "R3 crit above");
        check("R3 crit above", ct_out, 0);

        // R6 comparator mode ignores reads and shutdown
        step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, "R6 read");
        step(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, "R6 status read");
        step(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, "R6 shutdown");
        check("R6 int held", int_out, 0);
        check("R6 ct held", ct_out, 0);

        // R5 active-high polarity
        cfg_word = 8'h1C; do_reset();
        conv(16'h1000, "R5");
        check("R5 int inactive low", int_out, 0);
        check("R5 ct inactive low", ct_out, 0);
        conv(16'h2100, "R5");
        check("R5 int active high", int_out, 1);

        // R7 and R8 interrupt mode
        cfg_word = 8'h00; do_reset();
        conv(16'h4A00, "R7 set");
        check("R7 int active", int_out, 0);
        check("R7 ct active", ct_out, 0);
        step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, "R7 read");
        check("R7 read clears int", int_out, 1);
        check("R7 read clears ct", ct_out, 1);
        conv(16'h4A00, "R8 no rearm");
        check("R8 int stays clear", int_out, 1);
        check("R8 ct stays clear", ct_out, 1);
        conv(16'h1000, "R8 rearm");
        conv(16'h4A00, "R8 new crossing");
        check("R8 int re-asserts", int_out, 0);
        step(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, "R7 shutdown");
        check("R7 shutdown clears int", int_out, 1);
        check("R7 shutdown keeps ct", ct_out, 0);

        // R9 status flags
        cfg_word = 8'h10; do_reset();
        conv(16'h2100, "R9");
        check("R9 high flag set", status_flags, 3'b010);
        step(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, "R9 status read");
        check("R9 status read clears", status_flags, 3'b000);
        conv(16'h2100, "R9");
        conv(16'h1000, "R9");
        check("R9 release clears", status_flags, 3'b000);

        // R10 value word formats
        cfg_word = 8'h90; do_reset();
        conv(16'h2105, "R10");
        check("R10 16-bit word", value_word, 16'h2105);
        cfg_word = 8'h10;
        #1;
        check("R10 13-bit word", value_word, 16'h2102);

        // Random phases: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int ph = 0; ph < 8; ph++) begin
            cfg_word = 8'($urandom) & 8'h9F;
            hyst_deg = 4'($urandom);
            do_reset();
            for (int k = 0; k < 400; k++) begin
                int anchor, base, hh;
                logic v, rd, srd, sd;
                logic [15:0] r;
                hh = int'(hyst_deg) * 128;
                anchor = $urandom_range(0, 5);
                case (anchor)
                    0: base = 16'h2000;
                    1: base = 16'h0500;
                    2: base = 16'h4980;
                    3: base = 16'h2000 - hh;
                    4: base = 16'h0500 + hh;
                    default: base = 16'h4980 - hh;
                endcase
                r = 16'(base + $urandom_range(0, 6) - 3);
                if ($urandom_range(0, 7) == 0) r = 16'($urandom);
                v   = ($urandom_range(0, 1) == 1);
                rd  = ($urandom_range(0, 7) == 0);
                srd = ($urandom_range(0, 7) == 0);
                sd  = !v && ($urandom_range(0, 15) == 0);
                step(v, r, rd, srd, sd, "random R3 R4 R6 R7 R8 R9 R10");
            end
        end

        finish_run();
    end

endmodule